// File: doc/BRIEF.md
# Indexed-Port Byte Store Window

This block reaches a battery-backed byte store through a four-byte I/O window rather than through a direct memory map. Software loads a 16-bit pointer one byte at a time: one port offset holds the low byte, another holds the high byte. A third offset moves a data byte to or from the location the pointer names. After each data store the pointer returns to zero. A data read leaves the pointer where it was, so the same location can be read again.

Two fixed 16-byte windows near the bottom of the store can be fenced off by a two-bit lock register. While a window's lock bit is set, stores into it are dropped and reads from it return all ones. Addresses at or beyond the configured store size behave in the same way. They do not wrap onto lower locations. Clock and alarm registers at the top of the map are handled elsewhere.

Top module: `nvw_port_window`

## Requirements
- R1: A write to offset 0 replaces bits 7:0 of the pointer and leaves bits 15:8 unchanged.
- R2: A write to offset 1 replaces bits 15:8 of the pointer and leaves bits 7:0 unchanged.
- R3: A write to offset 3 stores the data byte at the pointed location, and the pointer reads as zero from the next cycle.
- R4: A read strobe at offset 3 puts the byte at the pointed location on `io_rdata` one clock later. The pointer is not changed by the read, and `io_rdata` holds until the next read strobe.
- R5: A read strobe at offset 0, 1 or 2 gives 0xFF on `io_rdata` one clock later. A write to offset 2 changes neither the pointer nor the store.
- R6: While lock bit 0 is set, locations 0x20 to 0x2F read as 0xFF and ignore stores. 0x1F and 0x30 are not affected.
- R7: While lock bit 1 is set, locations 0x30 to 0x3F read as 0xFF and ignore stores. 0x2F and 0x40 are not affected.
- R8: A pointer value at or above RAM_SIZE (default 2048) reads as 0xFF and ignores stores. It does not alias onto a lower location.
- R9: Synchronous reset clears the pointer and both lock bits and drives `io_rdata` to 0xFF. The store contents survive reset.
- R10: A `lock_we` pulse loads `lock_wdata` into the lock bits (bit 0 for the lower window, bit 1 for the upper). Clearing a bit makes the bytes held before the lock visible again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_off | input | 2 | Window offset: 0 pointer low, 1 pointer high, 2 unused, 3 data |
| io_wr | input | 1 | Write strobe, one cycle |
| io_rd | input | 1 | Read strobe, one cycle |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data, valid the cycle after `io_rd` |
| lock_we | input | 1 | Load strobe for the lock bits |
| lock_wdata | input | 2 | New lock bits |

## Verification
On every cycle the assertions check how the pointer moves under each write offset and that it holds when no write occurs. They also check that the store is never written inside a locked window or outside the store size, that reads at the other offsets and blocked reads return all ones, and how the lock register loads and resets. Only the bench scenarios can show the data path itself: which byte comes back from which pointer, that an out-of-range address does not alias onto a low location, and that locked bytes come back unchanged after unlocking. They can also show that the store survives reset while the pointer and the locks do not.

// File: rtl/nvw_pkg.sv
package nvw_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    OFF_PTR_LO = 2'd0,
    OFF_PTR_HI = 2'd1,
    OFF_SPARE  = 2'd2,
    OFF_DATA   = 2'd3
  } port_off_e;

  localparam logic [BYTE_W-1:0] ALL_ONES = {BYTE_W{1'b1}};
endpackage

// File: rtl/nvw_ptr_latch.sv
module nvw_ptr_latch
  import nvw_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [1:0]        off,
  input  logic [BYTE_W-1:0] wdata,
  output logic [ADDR_W-1:0] ptr
);
  localparam int unsigned HI_W = ADDR_W - BYTE_W;

  logic [ADDR_W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (wr) begin
      case (port_off_e'(off))
        OFF_PTR_LO: ptr_q[BYTE_W-1:0]      <= wdata;
        OFF_PTR_HI: ptr_q[ADDR_W-1:BYTE_W] <= wdata[HI_W-1:0];
        OFF_DATA:   ptr_q                  <= '0;
        default:    ptr_q                  <= ptr_q;
      endcase
    end
  end

  assign ptr = ptr_q;

  p_lo_load_r1: assert property (@(posedge clk) disable iff (rst)
    (wr && off == 2'd0) |=> (ptr_q[BYTE_W-1:0] == $past(wdata)) &&
                            (ptr_q[ADDR_W-1:BYTE_W] == $past(ptr_q[ADDR_W-1:BYTE_W])));

  p_hi_load_r2: assert property (@(posedge clk) disable iff (rst)
    (wr && off == 2'd1) |=> (ptr_q[ADDR_W-1:BYTE_W] == $past(wdata[HI_W-1:0])) &&
                            (ptr_q[BYTE_W-1:0] == $past(ptr_q[BYTE_W-1:0])));

  p_clear_after_store_r3: assert property (@(posedge clk) disable iff (rst)
    (wr && off == 2'd3) |=> (ptr_q == '0));

  // R4 and R5: reads and the spare offset leave the pointer alone
  p_hold_no_write_r4: assert property (@(posedge clk) disable iff (rst)
    (!wr || off == 2'd2) |=> $stable(ptr_q));

  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (ptr_q == '0));
endmodule

// File: rtl/nvw_lock_guard.sv
module nvw_lock_guard
  import nvw_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned NUM_LOCK  = 2,
  parameter int unsigned LOCK_BASE = 32,
  parameter int unsigned LOCK_SPAN = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                lock_we,
  input  logic [NUM_LOCK-1:0] lock_wdata,
  input  logic [ADDR_W-1:0]   addr,
  output logic [NUM_LOCK-1:0] lock_bits,
  output logic                blocked
);
  logic [NUM_LOCK-1:0] lock_q;
  logic [NUM_LOCK-1:0] hit;
  logic [31:0]         addr_ext;

  assign addr_ext = 32'(addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= '0;
    end else if (lock_we) begin
      lock_q <= lock_wdata;
    end
  end

  for (genvar g = 0; g < NUM_LOCK; g++) begin : g_win
    localparam int unsigned LO = LOCK_BASE + g * LOCK_SPAN;
    localparam int unsigned HI = LO + LOCK_SPAN;
    assign hit[g] = lock_q[g] && (addr_ext >= 32'(LO)) && (addr_ext < 32'(HI));
  end

  assign blocked   = |hit;
  assign lock_bits = lock_q;

  p_lock_load_r10: assert property (@(posedge clk) disable iff (rst)
    lock_we |=> (lock_q == $past(lock_wdata)));

  p_lock_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !lock_we |=> $stable(lock_q));

  p_lock_reset_r9: assert property (@(posedge clk)
    rst |=> (lock_q == '0));
endmodule

// File: rtl/nvw_ram.sv
module nvw_ram
  import nvw_pkg::*;
#(
  parameter int unsigned DEPTH = 2048,
  parameter int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BYTE_W-1:0] wd,
  output logic [BYTE_W-1:0] rq
);
  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[idx] <= wd;
    end
    if (re) begin
      rq <= mem[idx];
    end
  end
endmodule

// File: rtl/nvw_port_window.sv
module nvw_port_window
  import nvw_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned RAM_SIZE  = 2048,
  parameter int unsigned NUM_LOCK  = 2,
  parameter int unsigned LOCK_BASE = 32,
  parameter int unsigned LOCK_SPAN = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          io_off,
  input  logic                io_wr,
  input  logic                io_rd,
  input  logic [7:0]          io_wdata,
  output logic [7:0]          io_rdata,
  input  logic                lock_we,
  input  logic [NUM_LOCK-1:0] lock_wdata
);
  localparam int unsigned IDX_W = $clog2(RAM_SIZE);

  logic [ADDR_W-1:0]   ptr;
  logic [NUM_LOCK-1:0] lock_bits;
  logic                blocked;
  logic                in_range;
  logic                permit;
  logic                acc_wr;
  logic                acc_rd;
  logic                ram_we;
  logic [BYTE_W-1:0]   ram_q;
  logic                ones_q;
  logic [31:0]         ptr_ext;

  nvw_ptr_latch #(.ADDR_W(ADDR_W)) u_ptr (
    .clk   (clk),
    .rst   (rst),
    .wr    (io_wr),
    .off   (io_off),
    .wdata (io_wdata),
    .ptr   (ptr)
  );

  nvw_lock_guard #(
    .ADDR_W    (ADDR_W),
    .NUM_LOCK  (NUM_LOCK),
    .LOCK_BASE (LOCK_BASE),
    .LOCK_SPAN (LOCK_SPAN)
  ) u_guard (
    .clk        (clk),
    .rst        (rst),
    .lock_we    (lock_we),
    .lock_wdata (lock_wdata),
    .addr       (ptr),
    .lock_bits  (lock_bits),
    .blocked    (blocked)
  );

  assign ptr_ext  = 32'(ptr);
  assign in_range = ptr_ext < 32'(RAM_SIZE);
  assign permit   = in_range && !blocked;
  assign acc_wr   = io_wr && (port_off_e'(io_off) == OFF_DATA);
  assign acc_rd   = io_rd && (port_off_e'(io_off) == OFF_DATA);
  assign ram_we   = acc_wr && permit;

  nvw_ram #(.DEPTH(RAM_SIZE), .IDX_W(IDX_W)) u_ram (
    .clk (clk),
    .we  (ram_we),
    .re  (acc_rd),
    .idx (ptr[IDX_W-1:0]),
    .wd  (io_wdata),
    .rq  (ram_q)
  );

  // Marks whether the last read must return all ones instead of the RAM byte
  always_ff @(posedge clk) begin
    if (rst) begin
      ones_q <= 1'b1;
    end else if (io_rd) begin
      ones_q <= !(acc_rd && permit);
    end
  end

  assign io_rdata = ones_q ? ALL_ONES : ram_q;

  p_other_offset_ones_r5: assert property (@(posedge clk) disable iff (rst)
    (io_rd && io_off != 2'd3) |=> (io_rdata == 8'hFF));

  p_blocked_read_ones_r6: assert property (@(posedge clk) disable iff (rst)
    (io_rd && io_off == 2'd3 && blocked) |=> (io_rdata == 8'hFF));

  p_oob_read_ones_r8: assert property (@(posedge clk) disable iff (rst)
    (io_rd && io_off == 2'd3 && ptr_ext >= 32'(RAM_SIZE)) |=> (io_rdata == 8'hFF));

  p_oob_no_store_r8: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (ptr_ext < 32'(RAM_SIZE)));

  p_lower_window_r6: assert property (@(posedge clk) disable iff (rst)
    (ram_we && lock_bits[0]) |-> !(ptr_ext >= 32'(LOCK_BASE) && ptr_ext < 32'(LOCK_BASE + LOCK_SPAN)));

  p_upper_window_r7: assert property (@(posedge clk) disable iff (rst)
    (ram_we && lock_bits[NUM_LOCK-1]) |->
      !(ptr_ext >= 32'(LOCK_BASE + (NUM_LOCK-1)*LOCK_SPAN) &&
        ptr_ext < 32'(LOCK_BASE + NUM_LOCK*LOCK_SPAN)));

  p_rdata_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !io_rd |=> $stable(io_rdata));

  p_reset_ones_r9: assert property (@(posedge clk)
    rst |=> (io_rdata == 8'hFF));
endmodule

// File: tb/nvw_port_window_tb.sv
module nvw_port_window_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] io_off = 2'd0;
  logic       io_wr = 1'b0;
  logic       io_rd = 1'b0;
  logic [7:0] io_wdata = 8'd0;
  logic [7:0] io_rdata;
  logic       lock_we = 1'b0;
  logic [1:0] lock_wdata = 2'd0;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  nvw_port_window dut_i (
    .clk        (clk),
    .rst        (rst),
    .io_off     (io_off),
    .io_wr      (io_wr),
    .io_rd      (io_rd),
    .io_wdata   (io_wdata),
    .io_rdata   (io_rdata),
    .lock_we    (lock_we),
    .lock_wdata (lock_wdata)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000 && !done) begin
      done = 1'b1;
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // kind 1 = store data at addr, kind 0 = read addr and expect data
  localparam int NV = 27;
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 16'h0010, 8'hA1}, {1'b1, 16'h0112, 8'hB2}, {1'b1, 16'h0212, 8'hC3},
    {1'b1, 16'h0213, 8'hD4}, {1'b1, 16'h07FF, 8'hE5}, {1'b1, 16'h0000, 8'h3C},
    {1'b1, 16'h001F, 8'h6B}, {1'b1, 16'h0020, 8'h5A}, {1'b1, 16'h002F, 8'h5B},
    {1'b1, 16'h0030, 8'h6A}, {1'b1, 16'h003F, 8'h6C}, {1'b1, 16'h0040, 8'h44},
    {1'b1, 16'h0800, 8'hEE},
    {1'b0, 16'h0010, 8'hA1}, {1'b0, 16'h0112, 8'hB2}, {1'b0, 16'h0212, 8'hC3},
    {1'b0, 16'h0213, 8'hD4}, {1'b0, 16'h07FF, 8'hE5}, {1'b0, 16'h0000, 8'h3C},
    {1'b0, 16'h001F, 8'h6B}, {1'b0, 16'h0020, 8'h5A}, {1'b0, 16'h002F, 8'h5B},
    {1'b0, 16'h0030, 8'h6A}, {1'b0, 16'h003F, 8'h6C}, {1'b0, 16'h0040, 8'h44},
    {1'b0, 16'h0800, 8'hFF}, {1'b0, 16'h0000, 8'h3C}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [1:0] off, input logic [7:0] d);
    @(negedge clk);
    io_off = off; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [1:0] off, output logic [7:0] d);
    @(negedge clk);
    io_off = off; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    d = io_rdata;
  endtask

  task automatic set_ptr(input logic [15:0] a);
    io_write(2'd0, a[7:0]);
    io_write(2'd1, a[15:8]);
  endtask

  task automatic store(input logic [15:0] a, input logic [7:0] d);
    set_ptr(a);
    io_write(2'd3, d);
  endtask

  task automatic fetch(input logic [15:0] a, output logic [7:0] d);
    set_ptr(a);
    io_read(2'd3, d);
  endtask

  task automatic load_lock(input logic [1:0] v);
    @(negedge clk);
    lock_wdata = v; lock_we = 1'b1;
    @(negedge clk);
    lock_we = 1'b0;
  endtask

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R9 rdata after reset", io_rdata, 8'hFF);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][24]) begin
        store(VEC[i][23:8], VEC[i][7:0]);
      end else begin
        fetch(VEC[i][23:8], r);
        chk((VEC[i][23:8] >= 16'h0800) ? "R8 table" : "R3/R4 table", r, VEC[i][7:0]);
      end
    end

    // R1: low byte replaced, high byte kept
    set_ptr(16'h0212);
    io_write(2'd0, 8'h13);
    io_read(2'd3, r);
    chk("R1 low load keeps high", r, 8'hD4);
    // R2: high byte replaced, low byte kept
    set_ptr(16'h0212);
    io_write(2'd1, 8'h01);
    io_read(2'd3, r);
    chk("R2 high load keeps low", r, 8'hB2);

    // R3: pointer clears after a store
    store(16'h0040, 8'h45);
    io_read(2'd3, r);
    chk("R3 pointer zero after store", r, 8'h3C);

    // R4: read does not move pointer
    fetch(16'h0010, r);
    chk("R4 first read", r, 8'hA1);
    io_read(2'd3, r);
    chk("R4 second read same pointer", r, 8'hA1);
    io_write(2'd3, 8'h77);
    fetch(16'h0010, r);
    chk("R4 store after read uses same pointer", r, 8'h77);
    repeat (2) @(negedge clk);
    chk("R4 rdata holds between reads", io_rdata, 8'h77);

    // R5: other offsets read ones; offset 2 write has no effect
    io_read(2'd0, r); chk("R5 offset 0 read", r, 8'hFF);
    io_read(2'd1, r); chk("R5 offset 1 read", r, 8'hFF);
    io_read(2'd2, r); chk("R5 offset 2 read", r, 8'hFF);
    set_ptr(16'h0040);
    io_write(2'd2, 8'h99);
    io_read(2'd3, r);
    chk("R5 offset 2 write ignored", r, 8'h45);

    // R6: lower window
    load_lock(2'b01);
    fetch(16'h0020, r); chk("R6 locked 0x20", r, 8'hFF);
    fetch(16'h002F, r); chk("R6 locked 0x2F", r, 8'hFF);
    store(16'h0020, 8'h11);
    store(16'h002F, 8'h12);
    fetch(16'h001F, r); chk("R6 0x1F unaffected", r, 8'h6B);
    fetch(16'h0030, r); chk("R6 0x30 unaffected", r, 8'h6A);
    load_lock(2'b00);
    fetch(16'h0020, r); chk("R10 0x20 after unlock", r, 8'h5A);
    fetch(16'h002F, r); chk("R10 0x2F after unlock", r, 8'h5B);

    // R7: upper window
    load_lock(2'b10);
    fetch(16'h0030, r); chk("R7 locked 0x30", r, 8'hFF);
    fetch(16'h003F, r); chk("R7 locked 0x3F", r, 8'hFF);
    store(16'h003F, 8'h13);
    fetch(16'h002F, r); chk("R7 0x2F unaffected", r, 8'h5B);
    fetch(16'h0040, r); chk("R7 0x40 unaffected", r, 8'h45);
    load_lock(2'b00);
    fetch(16'h003F, r); chk("R10 0x3F after unlock", r, 8'h6C);

    // R8: top of address space
    fetch(16'hFFFF, r); chk("R8 read 0xFFFF", r, 8'hFF);
    store(16'hFFFF, 8'h21);
    fetch(16'h07FF, r); chk("R8 no alias onto 0x7FF", r, 8'hE5);

    // R9: reset clears pointer and locks, keeps store
    load_lock(2'b11);
    set_ptr(16'h0025);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    chk("R9 rdata ones after reset", io_rdata, 8'hFF);
    io_read(2'd3, r);
    chk("R9 pointer zero, store kept", r, 8'h3C);
    store(16'h0025, 8'h78);
    fetch(16'h0025, r);
    chk("R9 locks cleared", r, 8'h78);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule